// File: doc/BRIEF.md
# I2C Target for a 16-bit Register Bank

This block is an I2C target that opens a bank of 16-bit registers to an I2C controller. Each register sits at a 16-bit address. After its device address, the controller sends a two-byte register address, most significant byte first. It then moves data in two-byte words, again most significant byte first. Both writes and reads carry on word after word through an internal address pointer. The pointer advances by two after every completed word and keeps its value between transactions.

SCL and SDA are open-drain lines. Both are sampled by a fast system clock through two-flop synchronizers. A start is an SDA fall while SCL is high, and a stop is an SDA rise while SCL is high. The target pulls SDA low through one drive-enable output. Register storage is outside the block and is reached through a simple port:
- address, write data and a one-cycle write strobe for writes;
- a one-cycle read strobe for reads, with read data expected on the next clock.

A read is a write phase that loads the pointer, then a repeated start with the R/W bit set. A read with no write phase starts at the current pointer. SCL must stay high and low for at least four system clocks each.

Top module: `i2c_reg16_target`

## Requirements
- R1: After reset the target releases SDA (sda_pull=0) and raises neither reg_we nor reg_re.
- R2: The target acknowledges (pulls SDA low in the ninth clock) only a device address byte whose upper seven bits equal DEV_ADDR. Any other address gets no acknowledge, and every later byte up to the next start or stop is ignored with no acknowledge and no strobe.
- R3: After the device byte (bit 0 = 0 for write) and two address bytes (high byte first), a data byte pair (high byte first) gives exactly one reg_we pulse. That pulse carries the loaded address on reg_addr and {high,low} on reg_wdata. It comes only after the low byte's acknowledge clock.
- R4: Further byte pairs in the same write are written to the address plus 2, plus 4 and so on.
- R5: A high data byte that is not followed by its low byte before a stop or a start produces no write.
- R6: A device byte with bit 0 = 1 raises reg_re once with reg_addr equal to the pointer. The target then shifts out the register's high byte and then its low byte, most significant bit first.
- R7: When the controller acknowledges a low read byte, the pointer advances by 2, reg_re fires for the new address, and the next pair is shifted out.
- R8: When the controller does not acknowledge a read byte, the target releases SDA and raises no further reg_re until the next start.
- R9: The pointer keeps its value across a stop. It equals the last loaded address plus 2 for each completed pair. A read with no write phase starts there.
- R10: A start seen in any state (a repeated start included) drops any unfinished byte, releases SDA, and expects a new device address byte. A stop releases SDA at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 16 | Register address for a write or read strobe |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Register read data, valid the clock after reg_re |

## Verification
The bench builds the target with DEV_ADDR set to 7'h35 rather than the default. That shows the address comparison follows the parameter, and lets a neighbouring address such as 7'h34 serve as the foreign device. The bus is driven with SCL half periods of ten system clocks, so every synchronizer delay and every set-up time on read data is exercised. Bursts of up to four words carry the pointer across several address steps. A current-address read and a repeated start cut in mid-pair show the pointer and the start handling.

// File: rtl/i2c_r16_pkg.sv
package i2c_r16_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } link_st_t;

  typedef enum logic [2:0] {
    FLD_DEV,
    FLD_AHI,
    FLD_ALO,
    FLD_DHI,
    FLD_DLO
  } field_t;
endpackage

// File: rtl/i2c_r16_sync.sv
module i2c_r16_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '1;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '1;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_r16_cond.sv
module i2c_r16_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_r16_ctrl.sv
module i2c_r16_ctrl
  import i2c_r16_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_lvl,
  output logic          sda_pull,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [AW-1:0] INC = AW'(STEP);

  link_st_t          st;
  field_t            fld;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, dhi;
  logic [AW-1:0]     ptr;
  logic [DW-1:0]     rd_hold;
  logic              rw, rd_cap, tx_lo, mack;
  logic [BYTE_W-1:0] next_tx;

  assign next_tx = tx_lo ? rd_hold[DW-1 -: BYTE_W] : rd_hold[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; fld <= FLD_DEV; bitcnt <= '0;
      rx_sh <= '0; tx_sh <= '0; dhi <= '0; ptr <= '0; rd_hold <= '0;
      rw <= 1'b0; rd_cap <= 1'b0; tx_lo <= 1'b0; mack <= 1'b0;
      sda_pull <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      reg_we <= 1'b0; reg_re <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      rd_cap <= reg_re;
      if (rd_cap) rd_hold <= reg_rdata;
      if (start_ev) begin
        st <= ST_RX; fld <= FLD_DEV; bitcnt <= '0; sda_pull <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE; sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt != FULL) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              if (fld == FLD_DEV && rx_sh[BYTE_W-1:1] != DEV_ADDR) begin
                st <= ST_SKIP;
              end else begin
                sda_pull <= 1'b1;
                st <= ST_RX_ACK;
                if (fld == FLD_DEV) rw <= rx_sh[0];
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_rise && fld == FLD_DEV && rw) begin
              reg_addr <= ptr;
              reg_re   <= 1'b1;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (fld == FLD_DEV && rw) begin
                st       <= ST_TX;
                tx_lo    <= 1'b0;
                tx_sh    <= rd_hold[DW-1 -: BYTE_W];
                sda_pull <= ~rd_hold[DW-1];
              end else begin
                st       <= ST_RX;
                sda_pull <= 1'b0;
                case (fld)
                  FLD_DEV: fld <= FLD_AHI;
                  FLD_AHI: begin ptr <= {ptr[AW-BYTE_W-1:0], rx_sh}; fld <= FLD_ALO; end
                  FLD_ALO: begin ptr <= {ptr[AW-BYTE_W-1:0], rx_sh}; fld <= FLD_DHI; end
                  FLD_DHI: begin dhi <= rx_sh; fld <= FLD_DLO; end
                  default: begin
                    reg_addr  <= ptr;
                    reg_wdata <= DW'({dhi, rx_sh});
                    reg_we    <= 1'b1;
                    ptr       <= ptr + INC;
                    fld       <= FLD_DHI;
                  end
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST) begin
                sda_pull <= 1'b0;
                mack     <= 1'b0;
                st       <= ST_TX_ACK;
              end else begin
                bitcnt   <= bitcnt + 1'b1;
                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_pull <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (tx_lo) ptr <= ptr + INC;
              if (sda_lvl) begin
                st <= ST_SKIP;
              end else begin
                mack <= 1'b1;
                if (tx_lo) begin
                  reg_addr <= ptr + INC;
                  reg_re   <= 1'b1;
                end
              end
            end else if (scl_fall && mack) begin
              st       <= ST_TX;
              bitcnt   <= '0;
              tx_lo    <= ~tx_lo;
              tx_sh    <= next_tx;
              sda_pull <= ~next_tx[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we);
  // R6
  re_pulse_chk: assert property (@(posedge clk) disable iff (rst) reg_re |=> !reg_re);
  // R6
  we_re_excl_chk: assert property (@(posedge clk) disable iff (rst) !(reg_we && reg_re));
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst) stop_ev |=> !sda_pull);
  // R2
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (rst) $rose(sda_pull) |-> $past(scl_fall));
  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst) (st == ST_SKIP) |-> (!sda_pull && !reg_re));
endmodule

// File: rtl/i2c_reg16_target.sv
module i2c_reg16_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_STEP   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  output logic [15:0] reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_we,
  output logic        reg_re,
  input  logic [15:0] reg_rdata
);
  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_r16_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_s)
  );

  i2c_r16_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_r16_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(16), .DW(16), .STEP(ADDR_STEP)) u_ctrl (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_lvl(line_s[0]),
    .sda_pull(sda_pull), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/sim_i2c_reg16_target.sv
module sim_i2c_reg16_target;
  localparam logic [6:0] DEV = 7'h35;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, reg_we, reg_re;
  logic [15:0] reg_addr, reg_wdata;
  logic [15:0] reg_rdata = 16'h0;
  wire sda_bus = m_sda & ~sda_pull;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] mem [logic [15:0]];
  logic [15:0] ref_mem [logic [15:0]];
  logic [31:0] exp_wq [$];
  logic [15:0] exp_rq [$];
  logic [15:0] ptr_m = 16'h0;

  always #2.5 clk = ~clk;

  i2c_reg16_target #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull(sda_pull),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // register bank behind the port
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] = reg_wdata;
    if (reg_re) reg_rdata <= mem.exists(reg_addr) ? mem[reg_addr] : 16'h0;
  end

  // every clock: compare strobes against the expected event queues
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      if (exp_wq.size() == 0) check(0, "R3 unexpected write", {reg_addr, reg_wdata}, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_wq.pop_front();
        check({reg_addr, reg_wdata} == e, "R3/R4 write", {reg_addr, reg_wdata}, e);
      end
    end
    if (!rst && reg_re) begin
      if (exp_rq.size() == 0) check(0, "R8 unexpected read", {16'h0, reg_addr}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_rq.pop_front();
        check(reg_addr == e, "R6/R7 read address", {16'h0, reg_addr}, {16'h0, e});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; tick(H); m_scl = 1; tick(H); m_sda = 0; tick(H); m_scl = 0; tick(3);
  endtask

  task automatic bus_stop();
    m_sda = 0; tick(H); m_scl = 1; tick(H); m_sda = 1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H - 3); m_scl = 1; tick(H); m_scl = 0; tick(3);
    end
    m_sda = 1; tick(H - 3); m_scl = 1; tick(H / 2); ack = !sda_bus; tick(H / 2); m_scl = 0; tick(3);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(H - 3); m_scl = 1; tick(H / 2); b[i] = sda_bus; tick(H / 2); m_scl = 0; tick(3);
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    tick(H - 3); m_scl = 1; tick(H); m_scl = 0; tick(3); m_sda = 1;
  endtask

  task automatic send_acked(input logic [7:0] b, input string req);
    bit a;
    send_byte(b, a);
    check(a, req, {31'h0, a}, 32'h1);
  endtask

  task automatic load_addr(input logic [15:0] addr);
    bus_start();
    send_acked({DEV, 1'b0}, "R2 own address ack");
    send_acked(addr[15:8], "R3 address high ack");
    send_acked(addr[7:0], "R3 address low ack");
    ptr_m = addr;
  endtask

  task automatic wr_words(input logic [15:0] addr, input logic [15:0] first, input int n);
    load_addr(addr);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = first + 16'(i * 16'h0101);
      exp_wq.push_back({ptr_m, d});
      ref_mem[ptr_m] = d;
      send_acked(d[15:8], "R3 data high ack");
      send_acked(d[7:0], "R4 data low ack");
      ptr_m = ptr_m + 16'd2;
    end
    bus_stop();
  endtask

  task automatic rd_words(input bit set_addr, input logic [15:0] addr, input int n, input string req);
    logic [7:0] hi, lo;
    logic [15:0] exp;
    if (set_addr) load_addr(addr);
    for (int i = 0; i < n; i++) exp_rq.push_back(ptr_m + 16'(2 * i));
    bus_start();
    send_acked({DEV, 1'b1}, "R6 read address ack");
    for (int i = 0; i < n; i++) begin
      exp = ref_mem.exists(ptr_m) ? ref_mem[ptr_m] : 16'h0;
      recv_byte(1'b1, hi);
      recv_byte(i != n - 1, lo);
      check({hi, lo} == exp, req, {16'h0, hi, lo}, {16'h0, exp});
      ptr_m = ptr_m + 16'd2;
    end
    check(sda_pull == 1'b0, "R8 released after NACK", {31'h0, sda_pull}, 32'h0);
    tick(2 * H);
    check(exp_rq.size() == 0, "R8 no extra read strobe", exp_rq.size(), 32'h0);
    bus_stop();
  endtask

  initial begin
    bit a;
    tick(4);
    rst = 0;
    tick(2);
    // R1
    check(sda_pull == 0 && reg_we == 0 && reg_re == 0, "R1 reset idle",
          {29'h0, sda_pull, reg_we, reg_re}, 32'h0);

    wr_words(16'h0010, 16'hA5C3, 1);              // R3
    wr_words(16'h0100, 16'h1001, 4);              // R4

    // R5: high byte only, then stop
    load_addr(16'h0200);
    send_acked(8'h5A, "R5 lone high ack");
    bus_stop();
    tick(H);
    check(exp_wq.size() == 0, "R5 partial discarded", exp_wq.size(), 32'h0);

    // R2: foreign device, then a trailing byte
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    check(!a, "R2 foreign address nack", {31'h0, a}, 32'h0);
    send_byte(8'h00, a);
    check(!a, "R2 following byte ignored", {31'h0, a}, 32'h0);
    bus_stop();

    // R10: repeated start cuts a pair, new transfer writes once
    load_addr(16'h0300);
    send_acked(8'h77, "R10 first high ack");
    load_addr(16'h0302);
    exp_wq.push_back({16'h0302, 16'h1234});
    ref_mem[16'h0302] = 16'h1234;
    send_acked(8'h12, "R10 data high ack");
    send_acked(8'h34, "R10 data low ack");
    ptr_m = 16'h0304;
    bus_stop();

    rd_words(1, 16'h0010, 1, "R6 single read data");
    rd_words(1, 16'h0100, 3, "R7 burst read data");
    rd_words(0, 16'h0000, 1, "R9 current-address read data");
    rd_words(1, 16'h0300, 2, "R10 read after restart");
    rd_words(1, 16'h0200, 1, "R5 discarded pair reads zero");

    tick(H);
    check(exp_wq.size() == 0, "R4 all writes seen", exp_wq.size(), 32'h0);
    check(sda_pull == 0, "R10 idle after stop", {31'h0, sda_pull}, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule